// File: doc/BRIEF.md
# Integer Divide / Remainder Unit

A purely combinational integer divider that delivers either the quotient or the remainder of a dividend divided by a divisor. Elaboration parameters fix the dividend width, the divisor width and the result width, whether the unit returns quotient or remainder, and whether each operand is signed. Signed arithmetic is used only when both operands are declared signed. In every other case both operands are unsigned.

Both operands are first widened to a common working width W, the largest of the three widths. Signed operands are sign-extended and unsigned operands are zero-extended. For signed use, each operand is reduced to its magnitude. A chain of W restoring stages then produces the quotient bits from most significant to least significant, and the final partial remainder is the remainder. A sign correction follows: the quotient truncates toward zero, and the remainder takes the sign of the dividend.

A zero divisor never leaves the output undefined. Each combination of mode and signedness has a fixed, fully specified result. The output is the low result-width bits of the W-bit result.

Top module: `divmod_unit`

## Requirements
- R1: With MODE=0 and unsigned operation, y_out is the low WY bits of floor(a/b), where a and b are the zero-extended unsigned values and b is non-zero.
- R2: With MODE=1 and unsigned operation, y_out is the low WY bits of a mod b for a non-zero divisor, and that remainder is always below b.
- R3: With MODE=0 and both operands signed, the quotient truncates toward zero. It is negative when the operand signs differ and the magnitude quotient is non-zero.
- R4: With MODE=1 and both operands signed, a non-zero remainder has the sign of the dividend, and its magnitude is below the magnitude of the divisor.
- R5: All arithmetic is carried out in W = max(WA, WB, WY) bits two's complement, and y_out keeps the low WY bits. For example, with W=4 the most negative dividend (-8) divided by -1 gives the bit pattern 1000.
- R6: For a signed quotient with b = 0, y_out is all ones when a >= 0 and the value 1 when a < 0.
- R7: For an unsigned quotient with b = 0, bits below WA of the W-bit result are one and the bits above are zero. y_out is the low WY bits of that result.
- R8: For a remainder with b = 0, the result carries the low min(WA, WB) bits of a. The bits above are copies of bit min(WA, WB)-1 when signed, and zero when unsigned.
- R9: When only one of A_SIGNED and B_SIGNED is 1, both operands are treated as unsigned. The unit then behaves exactly like the unsigned case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WA | Dividend |
| b_in | input | WB | Divisor |
| y_out | output | WY | Quotient (MODE=0) or remainder (MODE=1) |

## Verification
Whenever the divisor is non-zero, the embedded assertions check on every evaluation that the magnitude remainder is below the magnitude divisor and that quotient times divisor plus remainder rebuilds the dividend. They also check the sign of a corrected signed quotient and of a signed remainder. Only the bench's scenarios can show the following behaviours:
- the exact divide-by-zero patterns for each mode and signedness;
- the wrap of the most negative dividend divided by -1;
- the fallback to unsigned operation under mixed signedness;
- the truncation to the result width.

The bench exercises all of these exhaustively over small widths for six parameter sets.

// File: rtl/divmod_pkg.sv
package divmod_pkg;
   function automatic int max_of(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

   function automatic int min_of(input int x, input int y);
      return (x < y) ? x : y;
   endfunction
endpackage

// File: rtl/divmod_extend.sv
module divmod_extend #(
   parameter int WI     = 8,
   parameter int W      = 8,
   parameter bit SIGNED = 1'b0
) (
   input  logic [WI-1:0] val,
   output logic [W-1:0]  ext,
   output logic [W-1:0]  mag
);
   if (WI > W) begin : g_bad_width
      $error("divmod_extend: input wider than working width");
   end

   for (genvar g = 0; g < W; g++) begin : g_bit
      if (g < WI) begin : g_copy
         assign ext[g] = val[g];
      end else if (SIGNED) begin : g_sign
         assign ext[g] = val[WI-1];
      end else begin : g_zero
         assign ext[g] = 1'b0;
      end
   end

   if (SIGNED) begin : g_abs
      assign mag = ext[W-1] ? (~ext + W'(1)) : ext;
   end else begin : g_pass
      assign mag = ext;
   end
endmodule

// File: rtl/divmod_stage.sv
module divmod_stage #(
   parameter int W = 8
) (
   input  logic [W-1:0] part_in,
   input  logic         num_bit,
   input  logic [W-1:0] den,
   output logic [W-1:0] part_out,
   output logic         q_bit
);
   logic [W:0] shifted;

   assign shifted  = {part_in, num_bit};
   assign q_bit    = (shifted >= {1'b0, den});
   assign part_out = q_bit ? (shifted[W-1:0] - den) : shifted[W-1:0];
endmodule

// File: rtl/divmod_array.sv
module divmod_array #(
   parameter int W = 8
) (
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   localparam int W2 = 2 * W;

   logic [W-1:0] part [W+1];

   assign part[0] = '0;

   for (genvar s = 0; s < W; s++) begin : g_stage
      divmod_stage #(.W(W)) u_stage (
         .part_in  (part[s]),
         .num_bit  (num[W-1-s]),
         .den      (den),
         .part_out (part[s+1]),
         .q_bit    (quo[W-1-s])
      );
   end

   assign rem = part[W];

   always_comb begin
      if (den != '0) begin
         AST_REM_LT_DIVISOR: assert (rem < den)
            else $error("remainder not below divisor"); // R2
         AST_RECOMBINE: assert ((W2'(quo) * W2'(den) + W2'(rem)) == W2'(num))
            else $error("quotient and remainder do not rebuild dividend"); // R1
      end
   end
endmodule

// File: rtl/divmod_fixup.sv
module divmod_fixup
   import divmod_pkg::*;
#(
   parameter int W      = 8,
   parameter int WA     = 8,
   parameter int WB     = 8,
   parameter int WY     = 8,
   parameter int MODE   = 0,
   parameter bit SIGNED = 1'b0
) (
   input  logic [W-1:0]  a_ext,
   input  logic          b_neg,
   input  logic          b_zero,
   input  logic [W-1:0]  quo,
   input  logic [W-1:0]  rem,
   output logic [WY-1:0] y
);
   localparam int WM = min_of(WA, WB);

   if (WM > W || WY > W) begin : g_bad_width
      $error("divmod_fixup: width exceeds working width");
   end

   logic         a_neg;
   logic [W-1:0] full;
   logic [W-1:0] zres;

   assign a_neg = SIGNED && a_ext[W-1];

   always_comb begin
      if (MODE == 0) begin
         full = (SIGNED && (a_neg ^ b_neg)) ? (~quo + W'(1)) : quo;
      end else begin
         full = (SIGNED && a_neg) ? (~rem + W'(1)) : rem;
      end
   end

   if (MODE == 0 && SIGNED) begin : g_zq_signed
      assign zres = a_neg ? W'(1) : '1;
   end else if (MODE == 0) begin : g_zq_unsigned
      for (genvar g = 0; g < W; g++) begin : g_bit
         assign zres[g] = (g < WA);
      end
   end else begin : g_zr
      for (genvar g = 0; g < W; g++) begin : g_bit
         if (g < WM) begin : g_copy
            assign zres[g] = a_ext[g];
         end else if (SIGNED) begin : g_sext
            assign zres[g] = a_ext[WM-1];
         end else begin : g_zext
            assign zres[g] = 1'b0;
         end
      end
   end

   assign y = b_zero ? zres[WY-1:0] : full[WY-1:0];

   always_comb begin
      if (MODE == 1 && SIGNED && !b_zero && rem != '0) begin
         AST_REM_SIGN: assert (full[W-1] == a_neg)
            else $error("signed remainder sign differs from dividend"); // R4
      end
      if (MODE == 0 && SIGNED && !b_zero && quo != '0 && !quo[W-1]) begin
         AST_QUOT_SIGN: assert (full[W-1] == (a_neg ^ b_neg))
            else $error("signed quotient sign wrong"); // R3
      end
   end
endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
   import divmod_pkg::*;
#(
   parameter int WA       = 8,
   parameter int WB       = 8,
   parameter int WY       = 8,
   parameter int MODE     = 0,
   parameter bit A_SIGNED = 1'b0,
   parameter bit B_SIGNED = 1'b0
) (
   input  logic [WA-1:0] a_in,
   input  logic [WB-1:0] b_in,
   output logic [WY-1:0] y_out
);
   localparam int W      = max_of(max_of(WA, WB), WY);
   localparam bit SIGNED = A_SIGNED && B_SIGNED;

   if (WA < 1 || WB < 1 || WY < 1) begin : g_bad_width
      $error("divmod_unit: widths must be at least 1");
   end
   if (MODE != 0 && MODE != 1) begin : g_bad_mode
      $error("divmod_unit: MODE must be 0 or 1");
   end

   logic [W-1:0] a_ext, a_mag, b_ext, b_mag, quo, rem;
   logic         b_neg, b_zero;

   divmod_extend #(.WI(WA), .W(W), .SIGNED(SIGNED)) u_ext_a (
      .val (a_in), .ext (a_ext), .mag (a_mag)
   );

   divmod_extend #(.WI(WB), .W(W), .SIGNED(SIGNED)) u_ext_b (
      .val (b_in), .ext (b_ext), .mag (b_mag)
   );

   assign b_neg  = SIGNED && b_ext[W-1];
   assign b_zero = (b_ext == '0);

   divmod_array #(.W(W)) u_array (
      .num (a_mag), .den (b_mag), .quo (quo), .rem (rem)
   );

   divmod_fixup #(
      .W(W), .WA(WA), .WB(WB), .WY(WY), .MODE(MODE), .SIGNED(SIGNED)
   ) u_fixup (
      .a_ext  (a_ext),
      .b_neg  (b_neg),
      .b_zero (b_zero),
      .quo    (quo),
      .rem    (rem),
      .y      (y_out)
   );
endmodule

// File: tb/tb_divmod_unit.sv
module tb_divmod_unit;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [5:0] a_bus = '0;
   logic [4:0] b_bus = '0;

   logic [3:0] y0, y1, y4;
   logic [5:0] y2;
   logic [3:0] y3;
   logic [6:0] y5;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // signed quotient 4/4/4
   divmod_unit #(.WA(4), .WB(4), .WY(4), .MODE(0), .A_SIGNED(1), .B_SIGNED(1)) dut (
      .a_in(a_bus[3:0]), .b_in(b_bus[3:0]), .y_out(y0));
   // signed remainder 4/4/4
   divmod_unit #(.WA(4), .WB(4), .WY(4), .MODE(1), .A_SIGNED(1), .B_SIGNED(1)) dut_srem (
      .a_in(a_bus[3:0]), .b_in(b_bus[3:0]), .y_out(y1));
   // unsigned quotient 3/5/6
   divmod_unit #(.WA(3), .WB(5), .WY(6), .MODE(0), .A_SIGNED(0), .B_SIGNED(0)) dut_udiv (
      .a_in(a_bus[2:0]), .b_in(b_bus[4:0]), .y_out(y2));
   // unsigned remainder 6/3/4
   divmod_unit #(.WA(6), .WB(3), .WY(4), .MODE(1), .A_SIGNED(0), .B_SIGNED(0)) dut_urem (
      .a_in(a_bus[5:0]), .b_in(b_bus[2:0]), .y_out(y3));
   // mixed signedness quotient 4/4/4
   divmod_unit #(.WA(4), .WB(4), .WY(4), .MODE(0), .A_SIGNED(1), .B_SIGNED(0)) dut_mix (
      .a_in(a_bus[3:0]), .b_in(b_bus[3:0]), .y_out(y4));
   // signed remainder 5/3/7
   divmod_unit #(.WA(5), .WB(3), .WY(7), .MODE(1), .A_SIGNED(1), .B_SIGNED(1)) dut_wide (
      .a_in(a_bus[4:0]), .b_in(b_bus[2:0]), .y_out(y5));

   function automatic longint mask(input int w);
      return (longint'(1) << w) - 1;
   endfunction

   function automatic longint sx(input longint v, input int w);
      longint m = v & mask(w);
      return m[w-1] ? (m - (longint'(1) << w)) : m;
   endfunction

   function automatic longint model(input int wa, input int wb, input int wy,
                                    input int mode, input bit sa, input bit sb,
                                    input longint ar, input longint br);
      bit     sg = sa && sb;
      longint av = sg ? sx(ar, wa) : (ar & mask(wa));
      longint bv = sg ? sx(br, wb) : (br & mask(wb));
      longint res;
      int     wm = (wa < wb) ? wa : wb;
      if (bv == 0) begin
         if (mode == 0) res = sg ? ((av < 0) ? 1 : -1) : mask(wa);
         else           res = sg ? sx(ar, wm) : (ar & mask(wm));
      end else begin
         res = (mode == 0) ? (av / bv) : (av % bv);
      end
      return res & mask(wy);
   endfunction

   task automatic chk(input string tag, input longint got, input longint exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d",
                  tag, a_bus, b_bus, got, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int ai = 0; ai < 64; ai++) begin
         for (int bi = 0; bi < 32; bi++) begin
            @(negedge clk);
            a_bus = 6'(ai);
            b_bus = 5'(bi);
            @(posedge clk);
            #(CLK_PERIOD/4);
            // R6 zero divisor, R5 most negative over -1, R3 otherwise
            chk((b_bus[3:0] == 0) ? "R6" :
                ((a_bus[3:0] == 4'h8 && b_bus[3:0] == 4'hF) ? "R5" : "R3"),
                longint'(y0), model(4, 4, 4, 0, 1, 1, ai, bi));
            // R4 signed remainder, R8 remainder by zero
            chk((b_bus[3:0] == 0) ? "R8" : "R4",
                longint'(y1), model(4, 4, 4, 1, 1, 1, ai, bi));
            // R1 unsigned quotient, R7 unsigned divide by zero
            chk((b_bus[4:0] == 0) ? "R7" : "R1",
                longint'(y2), model(3, 5, 6, 0, 0, 0, ai, bi));
            // R2 unsigned remainder, R8 zero-extended remainder by zero
            chk((b_bus[2:0] == 0) ? "R8" : "R2",
                longint'(y3), model(6, 3, 4, 1, 0, 0, ai, bi));
            // R9 mixed signedness acts unsigned
            chk("R9", longint'(y4), model(4, 4, 4, 0, 1, 0, ai, bi));
            // R5 wide result width, R8 sign-extended remainder by zero
            chk((b_bus[2:0] == 0) ? "R8" : "R5",
                longint'(y5), model(5, 3, 7, 1, 1, 1, ai, bi));
         end
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule